// File: doc/BRIEF.md
# 1-Wire ROM Command Layer

This block is the addressing stage of a 1-Wire slave. It sits above a bit-slot engine, which handles line timing, and below the function layer. The bit-slot engine gives it three things: each received bit with a strobe, a request whenever the master opens a read slot, and a pulse for every detected bus reset. That pulse carries a flag telling whether the reset was long enough to count at standard speed.

After each bus reset the block collects an 8-bit ROM command. Depending on the command it does one of the following:

- sends its 64-bit identity;
- compares a received 64-bit code against that identity;
- runs the bit-by-bit search exchange, with an optional conditional variant;
- skips addressing altogether.

When addressing succeeds it raises a level that hands the bus to the function layer. It also keeps a speed flag that the overdrive commands set. The identity is built from a family code parameter and a serial number parameter, and its check byte is computed during elaboration.

Top module: `onewire_rom_layer`

## Requirements
- R1: After `bus_reset`, `func_grant` is 0 and the next 8 strobed bits on `rx_bit` are taken as a command byte, least significant bit first.
- R2: Command 33h makes the block drive its identity on 64 successive read slots, least significant bit first. The order is family code (default 20h), then the 48-bit serial number, then the check byte. `func_grant` rises after the 64th slot.
- R3: The check byte is the CRC of the first 56 identity bits, LSB first, with polynomial x^8+x^5+x^4+1 and a zero start value. Running all 64 identity bits through that generator gives zero.
- R4: Command 55h compares the next 64 received bits with the identity. A full match raises `func_grant`. Any differing bit leaves `func_grant` at 0 and stops all driving until the next bus reset.
- R5: Command CCh raises `func_grant` directly after the command byte.
- R6: Command F0h runs a search. For each identity bit, the block drives its bit on one read slot, then drives the complement on the next read slot, then receives the master's chosen bit. A chosen bit that differs ends participation until the next bus reset. `func_grant` rises after the 64th matching choice.
- R7: Command ECh behaves as F0h when `cond_flag` is 1 at the end of the command byte. Otherwise the block does not drive until the next bus reset.
- R8: Commands 3Ch and 69h set `overdrive` to 1 when their command byte completes. 3Ch then grants as CCh does, and 69h then compares as 55h does.
- R9: `overdrive` is cleared by a bus reset with `reset_long` = 1. A bus reset with `reset_long` = 0 leaves it unchanged. `rst_n` clears it.
- R10: Any other command byte leaves `func_grant` at 0 and the block silent until the next bus reset. A bus reset aborts any command in progress.
- R11: `tx_drive` is 1 only on identity or complement slots of a read or search. When `tx_drive` is 0, `tx_bit` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_reset | input | 1 | One-cycle pulse: a bus reset was detected |
| reset_long | input | 1 | Qualifies `bus_reset`: reset exceeded the standard-speed threshold |
| rx_valid | input | 1 | Strobe for a received bit |
| rx_bit | input | 1 | Received bit value |
| tx_req | input | 1 | One-cycle pulse: the current read slot is consumed |
| cond_flag | input | 1 | Alarm or power-on condition present (conditional search) |
| tx_bit | output | 1 | Bit to place on the current read slot |
| tx_drive | output | 1 | Block has a bit to send on the current read slot |
| func_grant | output | 1 | Addressing succeeded; function layer owns the bus |
| overdrive | output | 1 | Overdrive speed is active |

## Verification
The identity read is checked against an identity built from the parameters, and the bench re-runs the CRC over the bits it actually received. This separates a wrong bit order from a wrong check byte. Match is tried with the exact code and with a single flipped bit deep in the serial number. Search is tried with a master that always follows the device's bits and with one that diverges at bit 10, which shows both the bit/complement pairing and the exit on a differing choice. Conditional search is tried with the participation input low and high. The overdrive commands are combined with short and long resets to show that only a long reset clears the speed flag. An unknown command and a reset in the middle of a read show that a reset always brings the block back to command reception.

// File: rtl/onewire_rom_pkg.sv
// Package: shared state and operation types plus ROM command codes for the
// 1-Wire ROM command layer. Assumes 8-bit commands, LSB first on the wire.
package onewire_rom_pkg;

    localparam int CMD_W = 8;

    localparam logic [CMD_W-1:0] CMD_READ    = 8'h33;
    localparam logic [CMD_W-1:0] CMD_MATCH   = 8'h55;
    localparam logic [CMD_W-1:0] CMD_SEARCH  = 8'hF0;
    localparam logic [CMD_W-1:0] CMD_CSEARCH = 8'hEC;
    localparam logic [CMD_W-1:0] CMD_SKIP    = 8'hCC;
    localparam logic [CMD_W-1:0] CMD_ODSKIP  = 8'h3C;
    localparam logic [CMD_W-1:0] CMD_ODMATCH = 8'h69;

    typedef enum logic [2:0] {
        ST_WAIT,    // silent until next bus reset
        ST_CMD,     // collecting command byte
        ST_READ,    // sending identity
        ST_MATCH,   // comparing received code
        ST_SEARCH,  // bit / complement / choice triplets
        ST_GRANT    // function layer owns the bus
    } rom_state_t;

    typedef enum logic [2:0] {
        OP_READ, OP_MATCH, OP_SEARCH, OP_CSEARCH,
        OP_SKIP, OP_ODSKIP, OP_ODMATCH, OP_BAD
    } rom_op_t;

    typedef enum logic [1:0] {
        PH_OWN  = 2'd0,   // send own bit
        PH_INV  = 2'd1,   // send complement
        PH_PICK = 2'd2    // receive master's choice
    } search_ph_t;

endpackage

// File: rtl/onewire_rom_decode.sv
// Module: onewire_rom_decode
// Maps a completed command byte onto an operation code. Purely
// combinational; assumes the caller presents the byte only when complete.
module onewire_rom_decode
    import onewire_rom_pkg::*;
(
    input  logic [CMD_W-1:0] cmd_byte,
    output rom_op_t          op
);

    // Command byte to operation lookup
    always_comb begin
        unique case (cmd_byte)
            CMD_READ:    op = OP_READ;
            CMD_MATCH:   op = OP_MATCH;
            CMD_SEARCH:  op = OP_SEARCH;
            CMD_CSEARCH: op = OP_CSEARCH;
            CMD_SKIP:    op = OP_SKIP;
            CMD_ODSKIP:  op = OP_ODSKIP;
            CMD_ODMATCH: op = OP_ODMATCH;
            default:     op = OP_BAD;
        endcase
    end

endmodule

// File: rtl/onewire_rom_id.sv
// Module: onewire_rom_id
// Holds the device identity {check byte, serial, family} and returns the bit
// at a given index (index 0 = family bit 0). The check byte is a CRC of the
// family and serial fields, LSB first, poly x^8+x^5+x^4+1, start value zero.
// Assumes parameters are constant, so the CRC reduces to constants.
module onewire_rom_id #(
    parameter logic [7:0] FAMILY   = 8'h20,
    parameter int         SERIAL_W = 48,
    parameter logic [SERIAL_W-1:0] SERIAL = 48'h0000_5A3C_1E77,
    localparam int DATA_W = 8 + SERIAL_W,
    localparam int ID_W   = DATA_W + 8,
    localparam int IDX_W  = $clog2(ID_W)
) (
    input  logic [IDX_W-1:0] idx,
    output logic             id_bit
);

    logic [DATA_W-1:0] body;
    logic [7:0]        crc;
    logic [ID_W-1:0]   ident;

    assign body  = {SERIAL, FAMILY};
    assign ident = {crc, body};

    // Reflected CRC-8 over the body, one bit at a time
    always_comb begin
        logic fb;
        crc = '0;
        for (int i = 0; i < DATA_W; i++) begin
            fb  = crc[0] ^ body[i];
            crc = crc >> 1;
            if (fb) crc = crc ^ 8'h8C;
        end
    end

    // Bit select of the identity
    assign id_bit = ident[idx];

endmodule

// File: rtl/onewire_rom_layer.sv
// Module: onewire_rom_layer (top)
// ROM function stage of a 1-Wire slave on a bit-slot interface. After each
// bus reset it collects a command byte and performs read, match, search,
// conditional search, skip or their overdrive forms. Assumes rx_valid and
// tx_req are single-cycle strobes from a bit-slot engine, never together,
// and that tx_bit/tx_drive are sampled before tx_req consumes the slot.
module onewire_rom_layer
    import onewire_rom_pkg::*;
#(
    parameter logic [7:0] FAMILY   = 8'h20,
    parameter int         SERIAL_W = 48,
    parameter logic [SERIAL_W-1:0] SERIAL = 48'h0000_5A3C_1E77,
    localparam int ID_W   = SERIAL_W + 16,
    localparam int IDX_W  = $clog2(ID_W),
    localparam int CNT_W  = $clog2(CMD_W)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_reset,
    input  logic reset_long,
    input  logic rx_valid,
    input  logic rx_bit,
    input  logic tx_req,
    input  logic cond_flag,
    output logic tx_bit,
    output logic tx_drive,
    output logic func_grant,
    output logic overdrive
);

    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ID_W - 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CMD_W - 1);

    rom_state_t        state;
    search_ph_t        phase;
    logic [IDX_W-1:0]  idx;
    logic [CNT_W-1:0]  cmd_cnt;
    logic [CMD_W-1:0]  cmd_sr;
    logic [CMD_W-1:0]  cmd_next;
    rom_op_t           op;
    logic              id_bit;
    logic              last_bit;

    assign cmd_next = {rx_bit, cmd_sr[CMD_W-1:1]};
    assign last_bit = (idx == IDX_LAST);

    onewire_rom_decode u_decode (
        .cmd_byte (cmd_next),
        .op       (op)
    );

    onewire_rom_id #(
        .FAMILY   (FAMILY),
        .SERIAL_W (SERIAL_W),
        .SERIAL   (SERIAL)
    ) u_id (
        .idx    (idx),
        .id_bit (id_bit)
    );

    // Command sequencing: byte collection, then the chosen ROM operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_WAIT;
            phase   <= PH_OWN;
            idx     <= '0;
            cmd_cnt <= '0;
            cmd_sr  <= '0;
        end else if (bus_reset) begin
            state   <= ST_CMD;
            phase   <= PH_OWN;
            idx     <= '0;
            cmd_cnt <= '0;
        end else begin
            unique case (state)
                ST_CMD: if (rx_valid) begin
                    cmd_sr  <= cmd_next;
                    cmd_cnt <= cmd_cnt + 1'b1;
                    if (cmd_cnt == CNT_LAST) begin
                        unique case (op)
                            OP_READ:                state <= ST_READ;
                            OP_MATCH, OP_ODMATCH:   state <= ST_MATCH;
                            OP_SEARCH:              state <= ST_SEARCH;
                            OP_CSEARCH:             state <= cond_flag ? ST_SEARCH : ST_WAIT;
                            OP_SKIP, OP_ODSKIP:     state <= ST_GRANT;
                            default:                state <= ST_WAIT;
                        endcase
                    end
                end
                ST_READ: if (tx_req) begin
                    idx <= idx + 1'b1;
                    if (last_bit) state <= ST_GRANT;
                end
                ST_MATCH: if (rx_valid) begin
                    idx <= idx + 1'b1;
                    if (rx_bit != id_bit) state <= ST_WAIT;
                    else if (last_bit)    state <= ST_GRANT;
                end
                ST_SEARCH: begin
                    if (phase == PH_OWN && tx_req) phase <= PH_INV;
                    else if (phase == PH_INV && tx_req) phase <= PH_PICK;
                    else if (phase == PH_PICK && rx_valid) begin
                        phase <= PH_OWN;
                        idx   <= idx + 1'b1;
                        if (rx_bit != id_bit) state <= ST_WAIT;
                        else if (last_bit)    state <= ST_GRANT;
                    end
                end
                default: ;
            endcase
        end
    end

    // Speed flag: set by overdrive commands, cleared only by a long reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            overdrive <= 1'b0;
        else if (bus_reset)
            overdrive <= overdrive & ~reset_long;
        else if (state == ST_CMD && rx_valid && cmd_cnt == CNT_LAST &&
                 (op == OP_ODSKIP || op == OP_ODMATCH))
            overdrive <= 1'b1;
    end

    // Read-slot data: identity bit, or its complement in the second search step
    always_comb begin
        tx_drive = (state == ST_READ) ||
                   (state == ST_SEARCH && phase != PH_PICK);
        if (!tx_drive)
            tx_bit = 1'b1;
        else if (state == ST_SEARCH && phase == PH_INV)
            tx_bit = ~id_bit;
        else
            tx_bit = id_bit;
    end

    assign func_grant = (state == ST_GRANT);

endmodule

// File: rtl/onewire_rom_layer_chk.sv
// Module: onewire_rom_layer_chk
// Port-level properties of the ROM command layer, bound to every instance.
module onewire_rom_layer_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_reset,
    input logic reset_long,
    input logic rx_valid,
    input logic tx_req,
    input logic tx_drive,
    input logic func_grant,
    input logic overdrive
);

    // A bus reset always withdraws the grant
    assert_reset_drops_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> !func_grant);

    // Granting never coincides with driving the line
    assert_grant_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
        func_grant |-> !tx_drive);

    // Grant only rises on a bit event
    assert_grant_on_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(func_grant) |-> $past(rx_valid || tx_req));

    // Overdrive only switches on at the end of a received bit
    assert_od_on_rx_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overdrive) |-> $past(rx_valid));

    // Long reset clears overdrive
    assert_long_reset_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_reset && reset_long) |=> !overdrive);

    // Short reset keeps overdrive
    assert_short_reset_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_reset && !reset_long) |=> $stable(overdrive));

    // Overdrive never falls without a long reset
    assert_od_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(overdrive) |-> $past(bus_reset && reset_long));

endmodule

bind onewire_rom_layer onewire_rom_layer_chk u_chk (.*);

// File: tb/onewire_rom_layer_tb.sv
module onewire_rom_layer_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0]  FAM = 8'h20;
    localparam logic [47:0] SER = 48'h0000_5A3C_1E77;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_reset = 1'b0, reset_long = 1'b0;
    logic rx_valid = 1'b0, rx_bit = 1'b0, tx_req = 1'b0, cond_flag = 1'b0;
    logic tx_bit, tx_drive, func_grant, overdrive;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct { logic b; logic d; string tag; } exp_t;
    exp_t q[$];

    logic [63:0] ident;
    logic [7:0]  rx_crc;

    always #(CLK_PERIOD/2) clk = ~clk;

    onewire_rom_layer u_dut (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .reset_long(reset_long),
        .rx_valid(rx_valid), .rx_bit(rx_bit), .tx_req(tx_req), .cond_flag(cond_flag),
        .tx_bit(tx_bit), .tx_drive(tx_drive), .func_grant(func_grant), .overdrive(overdrive)
    );

    // Shift-register form of x^8+x^5+x^4+1, LSB-first input
    function automatic logic [7:0] crc_step(logic [7:0] s, logic in);
        logic fb;
        logic [7:0] n;
        fb = s[0] ^ in;
        n[7] = fb;       n[6] = s[7];      n[5] = s[6];      n[4] = s[5];
        n[3] = s[4] ^ fb; n[2] = s[3] ^ fb; n[1] = s[2];     n[0] = s[1];
        return n;
    endfunction

    // Monitor: compares each queued expectation with the read slot data
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (tx_bit !== e.b || tx_drive !== e.d) begin
                fails++;
                $display("FAIL %s: tx_bit/drive=%b/%b expected %b/%b", e.tag, tx_bit, tx_drive, e.b, e.d);
            end
            if (tx_drive === 1'b1) rx_crc = crc_step(rx_crc, tx_bit);
        end
    end

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    // Read slot: queue the expected value, let the monitor sample, then consume
    task automatic rd(input logic b, input logic d, input string tag);
        @(posedge clk); #1;
        q.push_back('{b: b, d: d, tag: tag});
        @(negedge clk); #1;
        tx_req = 1'b1;
        @(posedge clk); #1;
        tx_req = 1'b0;
    endtask

    task automatic wr(input logic b);
        @(negedge clk);
        rx_bit = b; rx_valid = 1'b1;
        @(posedge clk); #1;
        rx_valid = 1'b0;
    endtask

    task automatic wr_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) wr(v[i]);
    endtask

    task automatic breset(input logic lng);
        @(negedge clk);
        bus_reset = 1'b1; reset_long = lng;
        @(posedge clk); #1;
        bus_reset = 1'b0; reset_long = 1'b0;
    endtask

    task automatic settle;
        @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] c;
        c = 8'h00;
        for (int i = 0; i < 56; i++) c = crc_step(c, (i < 8) ? FAM[i] : SER[i-8]);
        ident = {c, SER, FAM};

        repeat (3) @(posedge clk); #1;
        rst_n = 1'b1;
        settle();
        check(func_grant, 1'b0, "R1 reset grant");
        check(overdrive, 1'b0, "R9 reset overdrive");
        check(tx_drive, 1'b0, "R11 reset drive");

        // R2 / R3: read identity
        breset(1'b1);
        check(func_grant, 1'b0, "R1 grant after bus reset");
        wr_byte(8'h33);
        rx_crc = 8'h00;
        for (int i = 0; i < 64; i++) rd(ident[i], 1'b1, "R2 identity bit");
        settle();
        check(rx_crc == 8'h00, 1'b1, "R3 crc residue zero");
        check(ident[7:0] == 8'h20, 1'b1, "R2 family code");
        check(func_grant, 1'b1, "R2 grant after read");

        // R4: match exact
        breset(1'b1);
        wr_byte(8'h55);
        for (int i = 0; i < 64; i++) wr(ident[i]);
        settle();
        check(func_grant, 1'b1, "R4 match grant");

        // R4: match with one differing bit
        breset(1'b1);
        wr_byte(8'h55);
        for (int i = 0; i < 64; i++) wr((i == 40) ? ~ident[i] : ident[i]);
        settle();
        check(func_grant, 1'b0, "R4 mismatch no grant");
        rd(1'b1, 1'b0, "R4 mismatch silent");

        // R5: skip
        breset(1'b1);
        wr_byte(8'hCC);
        settle();
        check(func_grant, 1'b1, "R5 skip grant");
        check(overdrive, 1'b0, "R5 skip no overdrive");

        // R6: full search following own bits
        breset(1'b1);
        wr_byte(8'hF0);
        for (int i = 0; i < 64; i++) begin
            rd(ident[i], 1'b1, "R6 own bit");
            rd(~ident[i], 1'b1, "R6 complement");
            wr(ident[i]);
        end
        settle();
        check(func_grant, 1'b1, "R6 search grant");

        // R6: search diverging at bit 10
        breset(1'b1);
        wr_byte(8'hF0);
        for (int i = 0; i < 11; i++) begin
            rd(ident[i], 1'b1, "R6 own bit");
            rd(~ident[i], 1'b1, "R6 complement");
            wr((i == 10) ? ~ident[i] : ident[i]);
        end
        rd(1'b1, 1'b0, "R6 left search silent");
        settle();
        check(func_grant, 1'b0, "R6 left search no grant");

        // R7: conditional search without and with condition
        cond_flag = 1'b0;
        breset(1'b1);
        wr_byte(8'hEC);
        rd(1'b1, 1'b0, "R7 no condition silent");
        cond_flag = 1'b1;
        breset(1'b1);
        wr_byte(8'hEC);
        rd(ident[0], 1'b1, "R7 condition own bit");
        rd(~ident[0], 1'b1, "R7 condition complement");
        cond_flag = 1'b0;

        // R8 / R9: overdrive skip, short reset keeps, long reset clears
        breset(1'b1);
        wr_byte(8'h3C);
        settle();
        check(overdrive, 1'b1, "R8 overdrive skip sets speed");
        check(func_grant, 1'b1, "R8 overdrive skip grant");
        breset(1'b0);
        settle();
        check(overdrive, 1'b1, "R9 short reset keeps overdrive");
        wr_byte(8'h33);
        rd(ident[0], 1'b1, "R9 read after short reset");
        breset(1'b1);
        settle();
        check(overdrive, 1'b0, "R9 long reset clears overdrive");

        // R8: overdrive match
        breset(1'b1);
        wr_byte(8'h69);
        settle();
        check(overdrive, 1'b1, "R8 overdrive match sets speed");
        check(func_grant, 1'b0, "R8 overdrive match awaiting code");
        for (int i = 0; i < 64; i++) wr(ident[i]);
        settle();
        check(func_grant, 1'b1, "R8 overdrive match grant");
        breset(1'b1);

        // R10: unknown command, then abort of a read
        breset(1'b1);
        wr_byte(8'hA5);
        settle();
        check(func_grant, 1'b0, "R10 unknown no grant");
        rd(1'b1, 1'b0, "R10 unknown silent");
        breset(1'b1);
        wr_byte(8'h33);
        for (int i = 0; i < 5; i++) rd(ident[i], 1'b1, "R10 partial read");
        breset(1'b1);
        wr_byte(8'hCC);
        settle();
        check(func_grant, 1'b1, "R10 reset aborts read");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule